// File: doc/BRIEF.md
# Posted-Write Queue with Read Forwarding

This block sits between a write-through cache and main memory. Processor writes (an address and a data word) are posted into a small in-order queue, so the processor never waits for memory to finish a write. A single memory port is shared between processor reads and the draining of queued writes. Reads that must go to memory take that port ahead of queued writes. Queued writes go out oldest first, in any cycle where no such read needs the port.

Every read address is compared against all queued write addresses. On a match, the block answers from the queue, using the youngest matching entry, and memory is not read, so stale memory contents are never returned. Two writes to the same address each take their own entry. Because entries drain strictly in arrival order, memory ends up holding the value written last.

The write port and the read request port use valid/ready. A transfer happens in a cycle where both are high. The requester may hold or change its request while ready is low. The block never takes a request that is not accepted. `rd_ready` may depend on `rd_addr` in the same cycle, because a forwarded read needs no memory. Read responses carry no back-pressure: a response appears exactly one cycle after acceptance. The memory port is a per-cycle request: an operation takes place in a cycle where `mem_valid` and `mem_ready` are both high. Read data is returned on `mem_rdata` in the following cycle.

Top module: `wbuf_fwd`

## Requirements
- R1: While fewer than DEPTH entries are queued, `wr_ready` is high, and an accepted write completes with no dependence on `mem_ready`.
- R2: While DEPTH entries are queued, `wr_ready` is low and no write is taken.
- R3: A read whose address matches no queued entry, presented while the queue is not full, drives the memory port with a read (`mem_valid`=1, `mem_we`=0, `mem_addr`=`rd_addr`) instead of a drain, and is accepted when `mem_ready` is high.
- R4: When the queue is full, the memory port carries a drain of the oldest entry (`mem_we`=1), and a read that would need memory is held with `rd_ready` low.
- R5: A read whose address matches a queued entry is accepted at once (`rd_ready`=1, even with `mem_ready` low), and no memory read is issued in that cycle.
- R6: When several entries match, the data comes from the most recently queued one. A write accepted in the same cycle as a read is not visible to that read.
- R7: Queued writes reach memory in the order they were accepted, each with its own address and data, so memory ends with the last value written to each address.
- R8: `rd_rsp_valid` is high exactly in the cycle after a read is accepted, with `rd_rsp_data` holding the forwarded word or the memory word.
- R9: `buf_empty` is high exactly when no entries are queued. After reset, `buf_empty`=1, `wr_ready`=1, `mem_valid`=0 and `rd_rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Queue can take a write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request accepted this cycle if valid |
| rd_addr | input | AW | Read address |
| rd_rsp_valid | output | 1 | Read data valid |
| rd_rsp_data | output | DW | Read data |
| mem_valid | output | 1 | Memory operation requested |
| mem_ready | input | 1 | Memory takes the operation this cycle |
| mem_we | output | 1 | 1 = drain write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Drain write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |
| buf_empty | output | 1 | No writes are queued |

## Verification
Two functions can fall in the same cycle here. A forwarded read is answered from the queue while the oldest entry drains to memory. A processor write can also be pushed in the same cycle a read compares addresses. The bench provokes the first by stalling memory to fill the queue with repeated addresses and then reading them. It provokes the second by writing and reading the same address in one cycle, and checks that the older value comes back. A long pseudo-random sweep over four hot addresses and a cold range runs with memory stalling about a quarter of the time. Every response is judged against a shadow copy of program-order memory. Memory contents are compared against that shadow after the final drain.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // What the shared memory port is doing in a given cycle
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_READ  = 2'd1,
    PORT_DRAIN = 2'd2
  } port_use_e;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] look_addr,
  output logic          hit,
  output logic [DW-1:0] hit_data,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic [DEPTH-1:0] match;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // One address comparator per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = (addr_q[i] == look_addr);
  end

  // Walk slots oldest to youngest; a later live match overrides, so the youngest wins
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = int'(head_q) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (k < int'(cnt_q) && match[PW'(idx)]) begin
        hit      = 1'b1;
        hit_data = data_q[PW'(idx)];
      end
    end
  end

  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= wrap_inc(tail_q);
      if (pop)  head_q <= wrap_inc(head_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  // R2: a full queue never takes another entry
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R7: nothing drains from an empty queue
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/wbuf_port.sv
module wbuf_port
  import wbuf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          hit,
  input  logic          full,
  input  logic          empty,
  input  logic          mem_ready,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          rd_ready,
  output logic          pop,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  port_use_e use_c;

  // A memory read wins unless the queue is full; otherwise drain the oldest entry
  always_comb begin
    if (rd_valid && !hit && !full) use_c = PORT_READ;
    else if (!empty)               use_c = PORT_DRAIN;
    else                           use_c = PORT_IDLE;
  end

  assign rd_ready  = hit || (!full && mem_ready);
  assign pop       = (use_c == PORT_DRAIN) && mem_ready;
  assign mem_valid = (use_c != PORT_IDLE);
  assign mem_we    = (use_c == PORT_DRAIN);
  assign mem_addr  = (use_c == PORT_READ) ? rd_addr : head_addr;
  assign mem_wdata = head_data;
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_rsp_valid,
  output logic [DW-1:0] rd_rsp_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          buf_empty
);
  logic          push, pop, hit, full, empty;
  logic [DW-1:0] hit_data, head_data;
  logic [AW-1:0] head_addr;
  logic          rsp_q, rsp_mem_q;
  logic [DW-1:0] fwd_q;

  assign wr_ready = !full;
  assign push     = wr_valid && !full;

  wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(wr_addr), .push_data(wr_data),
    .pop(pop), .look_addr(rd_addr),
    .hit(hit), .hit_data(hit_data),
    .head_addr(head_addr), .head_data(head_data),
    .full(full), .empty(empty)
  );

  wbuf_port #(.AW(AW), .DW(DW)) port_i (
    .rd_valid(rd_valid), .rd_addr(rd_addr), .hit(hit),
    .full(full), .empty(empty), .mem_ready(mem_ready),
    .head_addr(head_addr), .head_data(head_data),
    .rd_ready(rd_ready), .pop(pop),
    .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // Response stage: forwarded word is registered, memory word arrives a cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q     <= 1'b0;
      rsp_mem_q <= 1'b0;
      fwd_q     <= '0;
    end else begin
      rsp_q     <= rd_valid && rd_ready;
      rsp_mem_q <= rd_valid && rd_ready && !hit;
      if (rd_valid && hit) fwd_q <= hit_data;
    end
  end

  assign rd_rsp_valid = rsp_q;
  assign rd_rsp_data  = rsp_mem_q ? mem_rdata : fwd_q;
  assign buf_empty    = empty;

  // R3: an unmatched read takes the memory port ahead of draining
  p_read_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !hit && !full) |-> (mem_valid && !mem_we && mem_addr == rd_addr));
  // R4: a full queue always drains and holds back reads that need memory
  p_full_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rd_valid && !hit) |-> (mem_valid && mem_we && !rd_ready));
  // R5: a matched read is taken at once without a memory read
  p_fwd_no_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && hit) |-> (rd_ready && !(mem_valid && !mem_we)));
  // R8: response exactly one cycle after acceptance
  p_rsp_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rd_rsp_valid);
  p_rsp_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> !rd_rsp_valid);
  // R9: nothing is written to memory while the queue is empty
  p_empty_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> !(mem_valid && mem_we));
endmodule

// File: tb/wbuf_fwd_tb.sv
module wbuf_fwd_tb_top;
  localparam int DEPTH = 4;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int NADDR = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, rd_valid = 1'b0, mem_ready = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, rd_ready, rd_rsp_valid, mem_valid, mem_we, buf_empty;
  logic [DW-1:0] rd_rsp_data, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] mem_model [NADDR];
  logic [DW-1:0] shadow    [NADDR];
  int n_vec = 0, n_bad = 0;
  logic          pend = 1'b0;
  logic [DW-1:0] pend_d = '0;
  logic [15:0]   lfsr = 16'hACE1;

  always #10 clk = ~clk;  // 50 MHz

  wbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .buf_empty(buf_empty)
  );

  // Memory model: one operation per cycle, read data one cycle later
  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_we) mem_model[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem_model[mem_addr];
    end
  end

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a * 7 + 3);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: judge the previous response, drive new inputs, record handshakes
  task automatic step(input logic wv, input int wa, input int wd,
                      input logic rv, input int ra, input logic mr);
    @(negedge clk);
    if (pend) chk(rd_rsp_valid && rd_rsp_data == pend_d, "R8 read data",
                  int'({rd_rsp_valid, rd_rsp_data}), int'({1'b1, pend_d}));
    else if (rd_rsp_valid) chk(1'b0, "R8 spurious response", 1, 0);
    wr_valid = wv; wr_addr = AW'(wa); wr_data = DW'(wd);
    rd_valid = rv; rd_addr = AW'(ra); mem_ready = mr;
    #1;
    pend = 1'b0;
    if (rv && rd_ready) begin
      pend   = 1'b1;
      pend_d = shadow[AW'(ra)];
    end
    if (wv && wr_ready) shadow[AW'(wa)] = DW'(wd);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int exp_a [4];
    int exp_d [4];
    for (int a = 0; a < NADDR; a++) begin
      mem_model[a] = init_val(a);
      shadow[a]    = init_val(a);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(buf_empty && wr_ready && !mem_valid && !rd_rsp_valid, "R9 reset state",
        int'({buf_empty, wr_ready, mem_valid, rd_rsp_valid}), 4'b1100);

    // Fill with memory stalled; repeated address 1
    step(1, 1, 8'h11, 0, 0, 0);
    chk(wr_ready, "R1 write taken with memory stalled", int'(wr_ready), 1);
    step(1, 2, 8'h22, 1, 1, 0);
    chk(rd_ready, "R5 forwarded read accepted with memory stalled", int'(rd_ready), 1);
    chk(!(mem_valid && !mem_we), "R5 no memory read on forward", int'(mem_we), 1);
    step(1, 1, 8'h33, 1, 1, 0);   // same-cycle write invisible: expects 0x11 (R6)
    step(1, 3, 8'h44, 1, 1, 0);   // youngest of two matches: expects 0x33 (R6)
    // Queue full: (1,11) (2,22) (1,33) (3,44)
    step(1, 5, 8'h55, 1, 9, 0);
    chk(!wr_ready, "R2 write stalled when full", int'(wr_ready), 0);
    chk(mem_valid && mem_we && !rd_ready, "R4 full queue drains ahead of read",
        int'({mem_valid, mem_we, rd_ready}), 3'b110);
    chk(mem_addr == 4'd1, "R4 drain is oldest entry", int'(mem_addr), 1);
    step(0, 0, 0, 1, 3, 0);       // forwarded while full: expects 0x44 (R6)

    exp_a = '{1, 2, 1, 3};
    exp_d = '{8'h11, 8'h22, 8'h33, 8'h44};
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 0, 0, 0, 1);
      chk(mem_valid && mem_we && mem_addr == AW'(exp_a[k]) && mem_wdata == DW'(exp_d[k]),
          "R7 drain order", int'({mem_addr, mem_wdata}), int'({AW'(exp_a[k]), DW'(exp_d[k])}));
    end
    step(0, 0, 0, 0, 0, 1);
    chk(buf_empty && !mem_valid, "R9 empty after drain", int'({buf_empty, mem_valid}), 2'b10);

    // Read priority over a pending drain
    step(1, 6, 8'h66, 0, 0, 0);
    step(0, 0, 0, 1, 9, 0);
    chk(mem_valid && !mem_we && mem_addr == 4'd9 && !rd_ready, "R3 read takes port, waits on memory",
        int'({mem_valid, mem_we, rd_ready, mem_addr}), int'({3'b100, 4'd9}));
    chk(!buf_empty, "R9 not empty with one entry", int'(buf_empty), 0);
    step(0, 0, 0, 1, 9, 1);
    chk(rd_ready && !mem_we, "R3 read accepted ahead of drain", int'({rd_ready, mem_we}), 2'b10);
    step(0, 0, 0, 1, 1, 1);       // miss read of drained address: memory value 0x33 (R7)

    // Pseudo-random sweep
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], int'(lfsr[5:4]), int'(lfsr[15:8] ^ DW'(c)),
           lfsr[2], int'({lfsr[10], lfsr[7:6]}), lfsr[11] | lfsr[12]);
    end

    // Final drain and memory comparison
    for (int c = 0; c < 20; c++) step(0, 0, 0, 0, 0, 1);
    chk(buf_empty, "R9 empty after final drain", int'(buf_empty), 1);
    for (int a = 0; a < NADDR; a++)
      chk(mem_model[a] == shadow[a], "R7 memory holds last write", int'(mem_model[a]), int'(shadow[a]));

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule